// File: doc/BRIEF.md
# Cache Diagnostic Pattern Generator

This block produces the data words a cache tag-store diagnostic writes and reads back. A single pattern index walks through three families in turn. The first is a walking one, where one set bit moves left each step. The second is a walking zero, where one clear bit rotates left. The third is a value unique to each cache entry, built from the current row and column. The index boundaries between families are parameters. The output is always trimmed to the tag width.

A test loop pulses `init_i` once. It then pulses `next_i` for each pattern and reads `pat_o` in the following cycle. It stops when `more_o` comes back low. In the third family the output follows `row_i` and `col_i` combinationally. The test can therefore sweep every entry without stepping the index.

Top module: `cdp_gen`

## Requirements
- R1: After reset or an `init_i` pulse, `idx_o` is all ones, `more_o` is low and `pat_o` is zero.
- R2: A step from the all-ones index gives index 0 with stored pattern 0x0001. Each further step below boundary `B1` (default 16) doubles the stored pattern, and `pat_o` is the stored pattern masked to 15 bits. At index 15 that is 0.
- R3: The step that reaches index `B1` loads the stored pattern with 0xFFFE, so `pat_o` reads 0x7FFE.
- R4: Each step to an index in (`B1`, `B2`) (default `B2` = 32) rotates the 16-bit stored pattern left by one, with bit 15 moving into bit 0. `pat_o` is the result masked to 15 bits.
- R5: For indices in [`B2`, `B3`) (default `B3` = 48), the stored pattern is zero and `pat_o` = ((`row_i` << 3) | `col_i`) masked to 15 bits. `col_i` sits in bits 1:0 and bit 2 is zero. `pat_o` follows `row_i` and `col_i` in the same cycle.
- R6: After each accepted step, `more_o` is high exactly when the new index is below `LAST` (default 48).
- R7: A `next_i` pulse while the index is at or above `LAST` (and not all ones) leaves the index and stored pattern unchanged and drives `more_o` low.
- R8: `init_i` takes priority over a simultaneous `next_i`. In a cycle with neither strobe, all state is held.
- R9: Whenever the index lies outside [0, `B3`), `pat_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_i | input | 1 | Restart the pattern sequence |
| next_i | input | 1 | Advance to the next pattern |
| row_i | input | ROW_W (6) | Cache row for the per-entry family |
| col_i | input | 2 | Cache column for the per-entry family |
| pat_o | output | TAG_W (15) | Current test pattern |
| idx_o | output | IDX_W (8) | Current pattern index |
| more_o | output | 1 | Last step landed on a valid pattern |

## Verification
A wrong stored pattern appears on `pat_o` in the cycle after the step that corrupts it. A rotation or doubling fault therefore shows within one step inside the first two families. A wrong index or boundary compare moves the family switch to the wrong step. That shifts `pat_o` at the boundary and also shifts the cycle in which `more_o` falls. The bench compares index, flag and pattern after every clock, so any such fault is seen in the first cycle it affects the ports.

// File: rtl/cdp_pkg.sv
// Shared definitions for the cache diagnostic pattern generator.
// Assumes the column field is two bits and sits below a 3-bit row shift.
package cdp_pkg;
    localparam int COL_W     = 2;
    localparam int ROW_SHIFT = 3;

    typedef enum logic [1:0] {
        FAM_ONE  = 2'd0,
        FAM_ZERO = 2'd1,
        FAM_UNIQ = 2'd2,
        FAM_NONE = 2'd3
    } cdp_fam_e;
endpackage

// File: rtl/cdp_index.sv
// Pattern index counter with end-of-sequence flag.
// Init parks the index at all ones so the first step lands on zero;
// once the index reaches LAST, further steps are refused.
module cdp_index #(
    parameter int IDX_W = 8,
    parameter int LAST  = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_i,
    input  logic             next_i,
    output logic [IDX_W-1:0] idx_q,
    output logic [IDX_W-1:0] nidx_o,
    output logic             step_o,
    output logic             more_q
);
    localparam logic [IDX_W-1:0] ALL1   = '1;
    localparam logic [IDX_W-1:0] LAST_C = IDX_W'(LAST);

    // Candidate next index and whether this strobe is accepted.
    always_comb begin
        nidx_o = idx_q + 1'b1;
        step_o = next_i && !init_i && ((idx_q == ALL1) || (idx_q < LAST_C));
    end

    // Index and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n || init_i) begin
            idx_q  <= ALL1;
            more_q <= 1'b0;
        end else if (next_i) begin
            if (step_o) begin
                idx_q  <= nidx_o;
                more_q <= (nidx_o < LAST_C);
            end else begin
                more_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cdp_pattern.sv
// Stored pattern register: walking one, walking zero, then cleared.
// Assumes step_i is only high for an accepted step and nidx_i is the new index.
module cdp_pattern #(
    parameter int IDX_W = 8,
    parameter int PAT_W = 16,
    parameter int B1    = 16,
    parameter int B2    = 32,
    parameter int B3    = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic [IDX_W-1:0] nidx_i,
    output logic [PAT_W-1:0] pat_q
);
    localparam logic [IDX_W-1:0] B1_C = IDX_W'(B1);
    localparam logic [IDX_W-1:0] B2_C = IDX_W'(B2);
    localparam logic [IDX_W-1:0] B3_C = IDX_W'(B3);
    localparam logic [PAT_W-1:0] ONE  = PAT_W'(1);

    logic [PAT_W-1:0] pat_d;

    // Next stored value chosen by the family of the new index.
    always_comb begin
        pat_d = pat_q;
        if (step_i) begin
            if (nidx_i < B1_C) begin
                pat_d = (nidx_i == '0) ? ONE : (pat_q << 1);
            end else if (nidx_i < B2_C) begin
                pat_d = (nidx_i == B1_C) ? ~ONE : {pat_q[PAT_W-2:0], pat_q[PAT_W-1]};
            end else if (nidx_i < B3_C) begin
                pat_d = '0;
            end
        end
    end

    // Pattern storage.
    always_ff @(posedge clk) begin
        if (!rst_n) pat_q <= '0;
        else        pat_q <= pat_d;
    end
endmodule

// File: rtl/cdp_shape.sv
// Output former: picks the family from the index and trims to tag width.
// Assumes ROW_W + 3 <= PAT_W and TAG_W <= PAT_W.
module cdp_shape
    import cdp_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int PAT_W = 16,
    parameter int TAG_W = 15,
    parameter int ROW_W = 6,
    parameter int B1    = 16,
    parameter int B2    = 32,
    parameter int B3    = 48
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic [PAT_W-1:0] pat_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [COL_W-1:0] col_i,
    output logic [TAG_W-1:0] pat_o
);
    localparam logic [IDX_W-1:0] B1_C = IDX_W'(B1);
    localparam logic [IDX_W-1:0] B2_C = IDX_W'(B2);
    localparam logic [IDX_W-1:0] B3_C = IDX_W'(B3);

    cdp_fam_e         fam;
    logic [PAT_W-1:0] uniq;
    logic [PAT_W-1:0] full;

    // Family decode from the registered index.
    always_comb begin
        if      (idx_i < B1_C) fam = FAM_ONE;
        else if (idx_i < B2_C) fam = FAM_ZERO;
        else if (idx_i < B3_C) fam = FAM_UNIQ;
        else                   fam = FAM_NONE;
    end

    // Per-entry value and full-width selection.
    always_comb begin
        uniq = pat_i | (PAT_W'(row_i) << ROW_SHIFT) | PAT_W'(col_i);
        unique case (fam)
            FAM_ONE, FAM_ZERO: full = pat_i;
            FAM_UNIQ:          full = uniq;
            default:           full = '0;
        endcase
    end

    // Trim to the tag width.
    generate
        if (TAG_W == PAT_W) begin : g_full
            assign pat_o = full;
        end else begin : g_trim
            assign pat_o = full[TAG_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/cdp_gen.sv
// Top of the cache diagnostic pattern generator.
// Index counter, pattern store and output former; pattern valid one
// cycle after a next strobe, row/column feed through combinationally.
module cdp_gen #(
    parameter int IDX_W = 8,
    parameter int PAT_W = 16,
    parameter int TAG_W = 15,
    parameter int ROW_W = 6,
    parameter int B1    = 16,
    parameter int B2    = 32,
    parameter int B3    = 48,
    parameter int LAST  = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_i,
    input  logic             next_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [1:0]       col_i,
    output logic [TAG_W-1:0] pat_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             more_o
);
    logic [IDX_W-1:0] nidx;
    logic             step;
    logic [PAT_W-1:0] pat_q;

    cdp_index #(.IDX_W(IDX_W), .LAST(LAST)) u_idx (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .next_i(next_i),
        .idx_q(idx_o), .nidx_o(nidx), .step_o(step), .more_q(more_o)
    );

    cdp_pattern #(.IDX_W(IDX_W), .PAT_W(PAT_W), .B1(B1), .B2(B2), .B3(B3)) u_pat (
        .clk(clk), .rst_n(rst_n), .step_i(step), .nidx_i(nidx), .pat_q(pat_q)
    );

    cdp_shape #(.IDX_W(IDX_W), .PAT_W(PAT_W), .TAG_W(TAG_W), .ROW_W(ROW_W),
                .B1(B1), .B2(B2), .B3(B3)) u_shape (
        .idx_i(idx_o), .pat_i(pat_q), .row_i(row_i), .col_i(col_i), .pat_o(pat_o)
    );
endmodule

// File: rtl/cdp_gen_chk.sv
// Port-level property checker for cdp_gen, attached by bind.
module cdp_gen_chk #(
    parameter int IDX_W = 8,
    parameter int TAG_W = 15,
    parameter int ROW_W = 6,
    parameter int B1    = 16,
    parameter int B2    = 32,
    parameter int B3    = 48,
    parameter int LAST  = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init_i,
    input logic             next_i,
    input logic [ROW_W-1:0] row_i,
    input logic [1:0]       col_i,
    input logic [TAG_W-1:0] pat_o,
    input logic [IDX_W-1:0] idx_o,
    input logic             more_o
);
    localparam logic [IDX_W-1:0] ALL1   = '1;
    localparam logic [IDX_W-1:0] B1_C   = IDX_W'(B1);
    localparam logic [IDX_W-1:0] B2_C   = IDX_W'(B2);
    localparam logic [IDX_W-1:0] B3_C   = IDX_W'(B3);
    localparam logic [IDX_W-1:0] LAST_C = IDX_W'(LAST);

    AST_INIT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (idx_o == ALL1) && !more_o && (pat_o == '0)); // R1
    AST_FIRST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_o == '0) |-> (pat_o == TAG_W'(1))); // R2
    AST_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_o < B1_C) |-> $onehot0(pat_o)); // R2
    AST_ZERO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_o == B1_C) |-> (pat_o == TAG_W'(~TAG_W'(1)))); // R3
    AST_ONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_o > B1_C && idx_o < B2_C) |-> ($countones(pat_o) >= TAG_W - 1)); // R4
    AST_UNIQ_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_o >= B2_C && idx_o < B3_C) |->
        (pat_o[1:0] == col_i) && !pat_o[2] && (pat_o[ROW_W+2:3] == row_i)); // R5
    AST_MORE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (next_i && !init_i && (idx_o == ALL1 || idx_o < LAST_C)) |=>
        (more_o == (idx_o < LAST_C))); // R6
    AST_EXHAUST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (next_i && !init_i && idx_o != ALL1 && idx_o >= LAST_C) |=>
        !more_o && $stable(idx_o)); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && !next_i) |=> $stable(idx_o) && $stable(more_o)); // R8
    AST_OUT_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_o >= B3_C) |-> (pat_o == '0)); // R9
endmodule

bind cdp_gen cdp_gen_chk #(
    .IDX_W(IDX_W), .TAG_W(TAG_W), .ROW_W(ROW_W),
    .B1(B1), .B2(B2), .B3(B3), .LAST(LAST)
) u_chk (
    .clk(clk), .rst_n(rst_n), .init_i(init_i), .next_i(next_i),
    .row_i(row_i), .col_i(col_i), .pat_o(pat_o), .idx_o(idx_o), .more_o(more_o)
);

// File: tb/sim_cdp_gen.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared after every clock.
module sim_cdp_gen;
    localparam int B1 = 16, B2 = 32, B3 = 48, LAST = 48;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       init_i = 1'b0;
    logic       next_i = 1'b0;
    logic [5:0] row_i = '0;
    logic [1:0] col_i = '0;
    logic [14:0] pat_o;
    logic [7:0]  idx_o;
    logic        more_o;

    int errs = 0;
    int checks = 0;
    int cycles = 0;
    int m_idx = -1;
    int m_pat = 0;
    bit m_more = 1'b0;

    cdp_gen u0 (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .next_i(next_i),
        .row_i(row_i), .col_i(col_i), .pat_o(pat_o), .idx_o(idx_o), .more_o(more_o)
    );

    always #2.5 clk = ~clk;

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errs++;
            $display("FAIL watchdog: actual=%0d cycles expected<100000", cycles);
            report();
        end
    end

    function automatic string pat_tag(int i);
        if (i < 0)   return "R1";
        if (i < B1)  return "R2";
        if (i == B1) return "R3";
        if (i < B2)  return "R4";
        if (i < B3)  return "R5";
        return "R9";
    endfunction

    function automatic int exp_pat();
        if (m_idx >= 0 && m_idx < B2) return m_pat & 32'h7FFF;
        if (m_idx >= B2 && m_idx < B3) return ((int'(row_i) << 3) | int'(col_i)) & 32'h7FFF;
        return 0;
    endfunction

    task automatic check(string itag);
        int ei;
        int ep;
        ei = (m_idx < 0) ? 255 : m_idx;
        ep = exp_pat();
        checks++;
        if (int'(idx_o) != ei) begin
            errs++;
            $display("FAIL %s idx: actual=%0d expected=%0d", itag, idx_o, ei);
        end
        checks++;
        if (more_o != m_more) begin
            errs++;
            $display("FAIL R6 more: actual=%0b expected=%0b", more_o, m_more);
        end
        checks++;
        if (int'(pat_o) != ep) begin
            errs++;
            $display("FAIL %s pat: actual=%h expected=%h", pat_tag(m_idx), pat_o, ep);
        end
    endtask

    // Reference model update for one clock edge.
    task automatic model(bit ini, bit nxt);
        int n;
        if (ini) begin
            m_idx = -1;
            m_more = 1'b0;
        end else if (nxt) begin
            if (m_idx < LAST) begin
                n = m_idx + 1;
                if (n < B1)       m_pat = (n == 0) ? 1 : ((m_pat * 2) & 32'hFFFF);
                else if (n < B2)  m_pat = (n == B1) ? 32'hFFFE
                                        : (((m_pat << 1) | (m_pat >> 15)) & 32'hFFFF);
                else if (n < B3)  m_pat = 0;
                m_idx = n;
                m_more = (n < LAST);
            end else begin
                m_more = 1'b0;
            end
        end
    endtask

    task automatic cyc(bit ini, bit nxt, int r, int c, string itag);
        @(negedge clk);
        init_i = ini;
        next_i = nxt;
        row_i = 6'(r);
        col_i = 2'(c);
        @(posedge clk);
        model(ini, nxt);
        @(negedge clk);
        init_i = 1'b0;
        next_i = 1'b0;
        #1 check(itag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1 check("R1");                       // reset state
        cyc(1, 0, 0, 0, "R1");                 // init
        for (int k = 0; k < LAST + 3; k++)     // full run then exhausted steps
            cyc(0, 1, k * 5 + 1, k, (k < LAST) ? "R6" : "R7");
        cyc(0, 0, 9, 2, "R8");                 // idle hold
        cyc(1, 1, 0, 0, "R8");                 // init beats next
        for (int k = 0; k < B2 + 2; k++)
            cyc(0, 1, 63 - k, 3 - (k % 4), "R2");
        for (int k = 0; k < 6; k++) begin      // row/col change, no step
            @(negedge clk);
            row_i = 6'(k * 11 + 7);
            col_i = 2'(k);
            #1 check("R5");
        end
        cyc(0, 0, 63, 3, "R8");
        cyc(1, 0, 0, 0, "R1");                 // mid-run restart
        for (int k = 0; k < 20; k++)
            cyc(0, 1, k, k, "R3");
        report();
    end
endmodule